// File: doc/BRIEF.md
# Fetch PC Prediction and Repair

This block sits in the fetch stage of a five-stage in-order pipeline. Each cycle it picks the address to fetch from. It also guesses the address of the instruction after the one being fetched. The guess is kept in a predicted-PC register and becomes the normal fetch address on the next cycle.

The guess depends on the class of the instruction now in fetch:
- Instructions that do not change control flow continue to the fall-through address.
- Jumps and calls go to their constant target.
- Conditional jumps are always guessed taken.
- Returns are not guessed. Their address is only known once the return has read the stack.

Later stages repair a wrong guess through two paths:
- A conditional jump that reaches the memory stage with its branch flag clear was mispredicted. Fetch restarts at the fall-through address, which that instruction carries in its operand A field.
- A return that reaches write-back supplies the address it loaded from data memory.

The stall and repair pins are plain control signals with no handshake. A caller that must hold fetch raises the hold pin, and the predicted-PC register keeps its value for that cycle. Squashing wrong-path instructions is left to the rest of the pipeline.

Top module: `fetch_pc_select`

## Requirements
- R1: While reset is low, the predicted-PC register clears to address 0. With no repair pending, the fetch PC is then 0.
- R2: Class codes are 3 bits: 0 plain, 1 unconditional jump, 2 call, 3 conditional jump, 4 return. Codes 0, 5, 6 and 7 are treated as plain, and their predicted next PC is the fall-through address.
- R3: For class 1 or class 2 in fetch, the predicted next PC is the constant target.
- R4: For class 3 in fetch, the predicted next PC is the constant target, meaning the jump is guessed taken.
- R5: For class 4 in fetch, the predicted next PC is the fall-through address as a placeholder, never the target.
- R6: When the memory-stage class is 3 and its branch flag is 0, the fetch PC equals the memory-stage operand A in that same cycle.
- R7: When the write-back class is 4 and R6 does not apply, the fetch PC equals the write-back memory result in that same cycle.
- R8: If R6 and R7 apply in the same cycle, the memory-stage repair wins.
- R9: A memory-stage class 3 with its flag set, or any other memory-stage class whatever the flag, causes no repair. The fetch PC is then the registered prediction.
- R10: While hold is 1, the predicted-PC register keeps its value across the clock edge.
- R11: While hold is 0, the predicted-PC register loads the current predicted next PC at the clock edge. The unrepaired fetch PC on the next cycle therefore equals this cycle's prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Fetch stall; keeps the predicted-PC register |
| f_cls_i | input | 3 | Class of the instruction in fetch |
| f_fall_i | input | AW | Fall-through address of the fetched instruction |
| f_tgt_i | input | AW | Constant target of the fetched instruction |
| m_cls_i | input | 3 | Class in the memory stage |
| m_taken_i | input | 1 | Branch flag in the memory stage |
| m_opa_i | input | AW | Operand A in the memory stage (fall-through of a conditional jump) |
| w_cls_i | input | 3 | Class in the write-back stage |
| w_mem_i | input | AW | Value loaded from data memory in write-back |
| fetch_pc_o | output | AW | Address to fetch this cycle |
| pred_pc_o | output | AW | Predicted address of the following instruction |

## Verification
The predicted-PC register is the only state, so a wrong stored value shows on fetch_pc_o exactly one cycle later, unless a repair masks it in that cycle. A missed load or a missed hold appears on the first cycle without a repair. A fault in the priority order appears only when both repair sources are active together, so those cycles are driven on purpose. The prediction output is combinational, so a wrong decode of a class is visible in the same cycle.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;
  typedef enum logic [2:0] {
    CLS_PLAIN = 3'd0,
    CLS_JMP   = 3'd1,
    CLS_CALL  = 3'd2,
    CLS_JCC   = 3'd3,
    CLS_RET   = 3'd4
  } icls_e;

  localparam int CLS_W = 3;

  // Next-PC source chosen by the fetch-stage guess.
  typedef enum logic [1:0] {
    GUESS_FALL = 2'd0,
    GUESS_TGT  = 2'd1,
    GUESS_NONE = 2'd2
  } guess_e;

  function automatic guess_e guess_of(input logic [CLS_W-1:0] cls);
    case (cls)
      CLS_JMP, CLS_CALL, CLS_JCC: guess_of = GUESS_TGT;
      CLS_RET:                    guess_of = GUESS_NONE;
      default:                    guess_of = GUESS_FALL;
    endcase
  endfunction
endpackage

// File: rtl/fetch_pc_guess.sv
module fetch_pc_guess
  import fetch_pc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic [AW-1:0]    fall_i,
  input  logic [AW-1:0]    tgt_i,
  output logic [AW-1:0]    pred_o
);
  guess_e kind;

  always_comb begin
    kind = guess_of(cls_i);
    unique case (kind)
      GUESS_TGT:  pred_o = tgt_i;
      // A return is not guessed; fall-through is a placeholder that the
      // write-back repair will replace.
      GUESS_NONE: pred_o = fall_i;
      default:    pred_o = fall_i;
    endcase
  end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int          AW     = 32,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q_o <= RST_PC;
    else if (!hold_i) q_o <= d_i;
  end

  a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(q_o));
  a_r11_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> q_o == $past(d_i));
endmodule

// File: rtl/fetch_pc_repair.sv
module fetch_pc_repair
  import fetch_pc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [CLS_W-1:0] m_cls_i,
  input  logic             m_taken_i,
  input  logic [AW-1:0]    m_opa_i,
  input  logic [CLS_W-1:0] w_cls_i,
  input  logic [AW-1:0]    w_mem_i,
  input  logic [AW-1:0]    pred_q_i,
  output logic [AW-1:0]    pc_o
);
  logic br_fix;
  logic ret_fix;

  always_comb begin
    br_fix  = (m_cls_i == CLS_JCC) && !m_taken_i;
    ret_fix = (w_cls_i == CLS_RET);
    if (br_fix)       pc_o = m_opa_i;
    else if (ret_fix) pc_o = w_mem_i;
    else              pc_o = pred_q_i;
  end
endmodule

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
  import fetch_pc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CLS_W-1:0] f_cls_i,
  input  logic [AW-1:0]    f_fall_i,
  input  logic [AW-1:0]    f_tgt_i,
  input  logic [CLS_W-1:0] m_cls_i,
  input  logic             m_taken_i,
  input  logic [AW-1:0]    m_opa_i,
  input  logic [CLS_W-1:0] w_cls_i,
  input  logic [AW-1:0]    w_mem_i,
  output logic [AW-1:0]    fetch_pc_o,
  output logic [AW-1:0]    pred_pc_o
);
  logic [AW-1:0] pred_q;

  fetch_pc_guess #(.AW(AW)) u_guess (
    .cls_i (f_cls_i),
    .fall_i(f_fall_i),
    .tgt_i (f_tgt_i),
    .pred_o(pred_pc_o)
  );

  fetch_pc_reg #(.AW(AW), .RST_PC('0)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .hold_i(hold_i),
    .d_i   (pred_pc_o),
    .q_o   (pred_q)
  );

  fetch_pc_repair #(.AW(AW)) u_repair (
    .m_cls_i  (m_cls_i),
    .m_taken_i(m_taken_i),
    .m_opa_i  (m_opa_i),
    .w_cls_i  (w_cls_i),
    .w_mem_i  (w_mem_i),
    .pred_q_i (pred_q),
    .pc_o     (fetch_pc_o)
  );

  a_r3_jump_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls_i == CLS_JMP || f_cls_i == CLS_CALL) |-> pred_pc_o == f_tgt_i);
  a_r4_jcc_guess_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls_i == CLS_JCC) |-> pred_pc_o == f_tgt_i);
  a_r6_mispredict_opa: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cls_i == CLS_JCC && !m_taken_i) |-> fetch_pc_o == m_opa_i);
  a_r7_ret_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cls_i == CLS_RET && !(m_cls_i == CLS_JCC && !m_taken_i))
      |-> fetch_pc_o == w_mem_i);
  a_r11_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i ##1 (!(m_cls_i == CLS_JCC && !m_taken_i) && w_cls_i != CLS_RET))
      |-> fetch_pc_o == $past(pred_pc_o));
endmodule

// File: tb/tb_fetch_pc_select.sv
module tb_fetch_pc_select;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_i = 1'b0;
  logic [2:0]    f_cls_i = 3'd0, m_cls_i = 3'd0, w_cls_i = 3'd0;
  logic [AW-1:0] f_fall_i = '0, f_tgt_i = '0, m_opa_i = '0, w_mem_i = '0;
  logic          m_taken_i = 1'b0;
  logic [AW-1:0] fetch_pc_o, pred_pc_o;

  always #5 clk = ~clk;

  fetch_pc_select #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
    .f_cls_i(f_cls_i), .f_fall_i(f_fall_i), .f_tgt_i(f_tgt_i),
    .m_cls_i(m_cls_i), .m_taken_i(m_taken_i), .m_opa_i(m_opa_i),
    .w_cls_i(w_cls_i), .w_mem_i(w_mem_i),
    .fetch_pc_o(fetch_pc_o), .pred_pc_o(pred_pc_o)
  );

  typedef struct {
    logic [AW-1:0] fetch;
    logic [AW-1:0] pred;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic [AW-1:0] m_pred = '0;
  logic [AW-1:0] m_pend = '0;
  bit   done = 0;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic step(input bit hold, input logic [2:0] fc, input logic [AW-1:0] fall,
                      input logic [AW-1:0] tgt, input logic [2:0] mc, input bit mt,
                      input logic [AW-1:0] opa, input logic [2:0] wc,
                      input logic [AW-1:0] wm, input string tag);
    exp_t e;
    @(negedge clk);
    m_pred = m_pend;
    hold_i = hold; f_cls_i = fc; f_fall_i = fall; f_tgt_i = tgt;
    m_cls_i = mc; m_taken_i = mt; m_opa_i = opa; w_cls_i = wc; w_mem_i = wm;
    e.pred  = (fc == 3'd1 || fc == 3'd2 || fc == 3'd3) ? tgt : fall;
    if (mc == 3'd3 && !mt) e.fetch = opa;
    else if (wc == 3'd4)   e.fetch = wm;
    else                   e.fetch = m_pred;
    e.tag = tag;
    q.push_back(e);
    m_pend = hold ? m_pred : e.pred;
  endtask

  // Monitor: samples away from the rising edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " fetch"}, fetch_pc_o, e.fetch);
        check({e.tag, " pred"},  pred_pc_o,  e.pred);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R1 reset fetch", fetch_pc_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    m_pend = '0;

    step(0, 3'd0, 32'h04, 32'h900, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R1_R2");
    step(0, 3'd5, 32'h14, 32'h910, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R2_c5");
    step(0, 3'd6, 32'h24, 32'h920, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R2_c6");
    step(0, 3'd7, 32'h34, 32'h930, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R2_c7");
    step(0, 3'd1, 32'h44, 32'h940, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R3_jmp");
    step(0, 3'd2, 32'h54, 32'h950, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R3_call");
    step(0, 3'd3, 32'h64, 32'h960, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R4");
    step(0, 3'd4, 32'h74, 32'h970, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R5");
    step(0, 3'd0, 32'h84, 32'h980, 3'd3, 0, 32'hA0, 3'd0, 32'h0, "R6");
    step(0, 3'd0, 32'h94, 32'h990, 3'd0, 0, 32'h0, 3'd4, 32'hB0, "R7");
    step(0, 3'd0, 32'hA4, 32'h9A0, 3'd3, 0, 32'hC0, 3'd4, 32'hD0, "R8");
    step(0, 3'd1, 32'hB4, 32'h9B0, 3'd3, 1, 32'hE0, 3'd0, 32'h0, "R9_taken");
    step(0, 3'd0, 32'hC4, 32'h9C0, 3'd1, 0, 32'hF0, 3'd2, 32'h1, "R9_other");
    step(1, 3'd1, 32'hD4, 32'h9D0, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R10_a");
    step(1, 3'd3, 32'hE4, 32'h9E0, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R10_b");
    step(0, 3'd0, 32'hF4, 32'h9F0, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R10_c");
    step(0, 3'd0, 32'h104, 32'hA00, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R11");

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[1], lfsr[4:2], {16'h0, lfsr}, {16'h1, lfsr ^ 16'h5A5A},
           lfsr[7:5], lfsr[8], {16'h2, lfsr}, lfsr[11:9], {16'h3, lfsr}, "R11_mix");
    end
    step(0, 3'd0, 32'h0, 32'h0, 3'd0, 0, 32'h0, 3'd0, 32'h0, "R11_end");
    @(negedge clk); #4;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule